// File: doc/BRIEF.md
# UART Interrupt Source and Mask Unit

This unit gathers the interrupt causes of a serial port into one request line. Four event sources feed a source register: receive, error, transmit and modem. A pulse on any of them latches its bit. A mask register hides selected sources. The pending register holds the unmasked sources, and the interrupt output is high whenever any pending bit is set.

The unit also raises the transmit source by itself. It does so while the transmit FIFO is enabled and its fill count is at or below a trigger level. That level is a 3-bit threshold field multiplied by a factor fixed by the channel number: 32 for channel 0, 8 for channels 1 and 4, 2 for channels 2 and 3, and 0 for any other channel. The channel is an elaboration parameter.

Software reaches the registers through a small port. It has a write strobe, a 2-bit address, and a read data bus driven combinationally from the registers. The source and pending registers are cleared by writing ones. Clearing through the pending register also clears the same source bits, even where the mask hides them.

Top module: `uart_irq_unit`

## Requirements
- R1: After reset the source, mask and pending registers read 0 and the interrupt output is low.
- R2: A one-cycle pulse on an event input sets its source bit, readable at address 0 after the next clock edge. The bits are: receive at bit 0, error at bit 1, transmit at bit 2, modem at bit 3.
- R3: The pending register (address 1) always equals the source bits ANDed with the inverse of the mask bits.
- R4: The interrupt output is high exactly when the pending register is nonzero.
- R5: Writing to address 1 clears every source bit written as one, masked or not, so both the source and pending registers lose those bits. Bits written as zero are unchanged.
- R6: Writing to address 0 clears the source bits written as one and leaves the others.
- R7: While the FIFO enable is high and the transmit fill count is at or below the trigger level, the transmit source bit is set every cycle. It is not set when the enable is low or the count is above the level.
- R8: The trigger level is the threshold field times 32 on channel 0, times 8 on channels 1 and 4, times 2 on channels 2 and 3, and 0 on any other channel.
- R9: A write to the mask register (address 2, read back at the same address) changes the pending register and the interrupt output after the same clock edge that stores the mask.
- R10: When an event and a clearing write reach the same source bit in the same cycle, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fifo_en | input | 1 | Transmit FIFO enabled |
| tx_trig_sel | input | TRIG_W | Transmit threshold field |
| tx_fill | input | CNT_W | Transmit FIFO fill count |
| ev_rx | input | 1 | Receive event pulse |
| ev_err | input | 1 | Error event pulse |
| ev_tx | input | 1 | Transmit event pulse |
| ev_modem | input | 1 | Modem event pulse |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 source, 1 pending, 2 mask, 3 reads zero |
| reg_wdata | input | NSRC | Write data |
| reg_rdata | output | NSRC | Read data for the selected register |
| irq | output | 1 | Level interrupt request |

## Verification
If a source bit is wrongly latched or wrongly cleared, it shows on the pending read and on irq one edge after the event or write that caused it. Nothing hides it for longer. A wrong mask value appears as a pending pattern that disagrees with the source and mask readbacks after a single write. A wrong trigger scale only shows at the threshold boundary, so the transmit request is probed at the level itself and one count above it, on several channel instances.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
    localparam int NSRC   = 4;
    localparam int SRC_RX = 0;
    localparam int SRC_ER = 1;
    localparam int SRC_TX = 2;
    localparam int SRC_MD = 3;

    typedef enum logic [1:0] {
        SEL_SRC  = 2'd0,
        SEL_PEND = 2'd1,
        SEL_MASK = 2'd2,
        SEL_RSVD = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [NSRC-1:0] src;
        logic [NSRC-1:0] mask;
        logic [NSRC-1:0] pend;
        logic            irq;
    } irq_state_t;

    // per-channel multiplier of the transmit threshold field
    function automatic int chan_scale(input int ch);
        case (ch)
            0:       return 32;
            1, 4:    return 8;
            2, 3:    return 2;
            default: return 0;
        endcase
    endfunction
endpackage

// File: rtl/uart_irq_txlvl.sv
module uart_irq_txlvl #(
    parameter int CHANNEL = 0,
    parameter int CNT_W   = 8,
    parameter int TRIG_W  = 3
) (
    input  logic              fifo_en,
    input  logic [TRIG_W-1:0] trig_sel,
    input  logic [CNT_W-1:0]  fill,
    output logic              tx_req
);
    import uart_irq_pkg::*;

    localparam int SCALE = chan_scale(CHANNEL);
    localparam int LVL_W = TRIG_W + 6;
    localparam int CMP_W = (CNT_W > LVL_W) ? CNT_W : LVL_W;

    logic [CMP_W-1:0] level;
    logic [CMP_W-1:0] fill_ext;

    always_comb begin
        level    = CMP_W'(trig_sel) * CMP_W'(SCALE);
        fill_ext = CMP_W'(fill);
        tx_req   = fifo_en && (fill_ext <= level);
    end
endmodule

// File: rtl/uart_irq_core.sv
module uart_irq_core
    import uart_irq_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] ev_vec,
    input  logic            tx_req,
    input  logic            wr_en,
    input  logic [1:0]      addr,
    input  logic [NSRC-1:0] wdata,
    output logic [NSRC-1:0] src_q,
    output logic [NSRC-1:0] mask_q,
    output logic [NSRC-1:0] pend_q,
    output logic            irq_q
);
    irq_state_t st_d, st_q;
    reg_sel_e   sel;
    logic [NSRC-1:0] clr_vec;
    logic [NSRC-1:0] set_vec;

    assign sel = reg_sel_e'(addr);

    always_comb begin
        st_d    = st_q;
        clr_vec = '0;
        if (wr_en && (sel == SEL_SRC || sel == SEL_PEND)) begin
            clr_vec = wdata;
        end
        set_vec         = ev_vec;
        set_vec[SRC_TX] = set_vec[SRC_TX] | tx_req;
        // setting is applied after clearing: an event beats a clear
        st_d.src = (st_q.src & ~clr_vec) | set_vec;
        if (wr_en && sel == SEL_MASK) begin
            st_d.mask = wdata;
        end
        st_d.pend = st_d.src & ~st_d.mask;
        st_d.irq  = |st_d.pend;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign src_q  = st_q.src;
    assign mask_q = st_q.mask;
    assign pend_q = st_q.pend;
    assign irq_q  = st_q.irq;
endmodule

// File: rtl/uart_irq_unit.sv
module uart_irq_unit
    import uart_irq_pkg::*;
#(
    parameter int CHANNEL = 0,
    parameter int CNT_W   = 8,
    parameter int TRIG_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fifo_en,
    input  logic [TRIG_W-1:0] tx_trig_sel,
    input  logic [CNT_W-1:0]  tx_fill,
    input  logic              ev_rx,
    input  logic              ev_err,
    input  logic              ev_tx,
    input  logic              ev_modem,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [NSRC-1:0]   reg_wdata,
    output logic [NSRC-1:0]   reg_rdata,
    output logic              irq
);
    logic [NSRC-1:0] ev_vec;
    logic [NSRC-1:0] src_vec;
    logic [NSRC-1:0] mask_vec;
    logic [NSRC-1:0] pend_vec;
    logic            tx_req;

    always_comb begin
        ev_vec         = '0;
        ev_vec[SRC_RX] = ev_rx;
        ev_vec[SRC_ER] = ev_err;
        ev_vec[SRC_TX] = ev_tx;
        ev_vec[SRC_MD] = ev_modem;
    end

    uart_irq_txlvl #(
        .CHANNEL (CHANNEL),
        .CNT_W   (CNT_W),
        .TRIG_W  (TRIG_W)
    ) u_txlvl (
        .fifo_en  (fifo_en),
        .trig_sel (tx_trig_sel),
        .fill     (tx_fill),
        .tx_req   (tx_req)
    );

    uart_irq_core u_core (
        .clk    (clk),
        .rst_n  (rst_n),
        .ev_vec (ev_vec),
        .tx_req (tx_req),
        .wr_en  (reg_wr),
        .addr   (reg_addr),
        .wdata  (reg_wdata),
        .src_q  (src_vec),
        .mask_q (mask_vec),
        .pend_q (pend_vec),
        .irq_q  (irq)
    );

    always_comb begin
        case (reg_sel_e'(reg_addr))
            SEL_SRC:  reg_rdata = src_vec;
            SEL_PEND: reg_rdata = pend_vec;
            SEL_MASK: reg_rdata = mask_vec;
            default:  reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/uart_irq_unit_chk.sv
module uart_irq_unit_chk
    import uart_irq_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            wr,
    input logic [1:0]      addr,
    input logic [NSRC-1:0] wdata,
    input logic [NSRC-1:0] ev,
    input logic            tx_req,
    input logic [NSRC-1:0] src_q,
    input logic [NSRC-1:0] mask_q,
    input logic [NSRC-1:0] pend_q,
    input logic            irq
);
    logic [NSRC-1:0] set_any;
    always_comb begin
        set_any         = ev;
        set_any[SRC_TX] = ev[SRC_TX] | tx_req;
    end

    assert_pend_match_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pend_q == (src_q & ~mask_q));

    assert_irq_level_R4: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (pend_q != '0));

    assert_event_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ev != '0) |=> ((src_q & $past(ev)) == $past(ev)));

    assert_tx_request_R7: assert property (@(posedge clk) disable iff (!rst_n)
        tx_req |=> src_q[SRC_TX]);

    assert_src_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == 2'd0) |=> ((src_q & $past(wdata & ~set_any)) == '0));

    assert_pend_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == 2'd1) |=> ((src_q & $past(wdata & ~set_any)) == '0));
endmodule

bind uart_irq_unit uart_irq_unit_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr     (reg_wr),
    .addr   (reg_addr),
    .wdata  (reg_wdata),
    .ev     (ev_vec),
    .tx_req (tx_req),
    .src_q  (src_vec),
    .mask_q (mask_vec),
    .pend_q (pend_vec),
    .irq    (irq)
);

// File: tb/uart_irq_unit_bench.sv
`timescale 1ns/1ps
module uart_irq_unit_bench;
    localparam int NALT = 3;
    localparam int ALT_CH [NALT] = '{1, 3, 7};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fifo_en = 1'b0;
    logic [2:0] trig = '0;
    logic [7:0] fill = '0;
    logic       ev_rx = 0, ev_err = 0, ev_tx = 0, ev_modem = 0;
    logic       wr = 1'b0;
    logic [1:0] addr = '0;
    logic [3:0] wdata = '0;
    logic [3:0] rdata;
    logic       irq;
    logic [3:0] alt_rdata [NALT];
    logic       alt_irq   [NALT];

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    uart_irq_unit #(.CHANNEL(0)) u_uart_irq_unit (
        .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .tx_trig_sel(trig),
        .tx_fill(fill), .ev_rx(ev_rx), .ev_err(ev_err), .ev_tx(ev_tx),
        .ev_modem(ev_modem), .reg_wr(wr), .reg_addr(addr),
        .reg_wdata(wdata), .reg_rdata(rdata), .irq(irq)
    );

    for (genvar k = 0; k < NALT; k++) begin : g_alt
        uart_irq_unit #(.CHANNEL(ALT_CH[k])) u_alt (
            .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .tx_trig_sel(trig),
            .tx_fill(fill), .ev_rx(ev_rx), .ev_err(ev_err), .ev_tx(ev_tx),
            .ev_modem(ev_modem), .reg_wr(wr), .reg_addr(addr),
            .reg_wdata(wdata), .reg_rdata(alt_rdata[k]), .irq(alt_irq[k])
        );
    end

    function automatic int exp_level(input int ch, input int f);
        case (ch)
            0:       return f * 32;
            1, 4:    return f * 8;
            2, 3:    return f * 2;
            default: return 0;
        endcase
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [3:0] d);
        @(negedge clk);
        wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr = 1'b0; wdata = '0;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [3:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic pulse(input logic [3:0] v);
        @(negedge clk);
        {ev_modem, ev_tx, ev_err, ev_rx} = v;
        @(negedge clk);
        {ev_modem, ev_tx, ev_err, ev_rx} = '0;
    endtask

    task automatic t_reset;
        logic [3:0] d;
        reg_read(2'd0, d); check("R1 source", d, 0);
        reg_read(2'd1, d); check("R1 pending", d, 0);
        reg_read(2'd2, d); check("R1 mask", d, 0);
        check("R1 irq", irq, 0);
    endtask

    task automatic t_events;
        logic [3:0] d;
        for (int i = 0; i < 4; i++) begin
            pulse(4'(1 << i));
            reg_read(2'd0, d); check("R2 source bit", d, 1 << i);
            check("R4 irq with one pending", irq, 1);
            reg_write(2'd0, 4'hF);
            reg_read(2'd0, d); check("R6 source cleared", d, 0);
            check("R4 irq low when nothing pending", irq, 0);
        end
    endtask

    task automatic t_mask_and_clear;
        logic [3:0] d;
        pulse(4'b1011);
        reg_read(2'd1, d); check("R3 pending unmasked", d, 4'b1011);
        reg_write(2'd2, 4'b1011);
        reg_read(2'd2, d); check("R9 mask readback", d, 4'b1011);
        reg_read(2'd1, d); check("R9 pending after mask", d, 0);
        check("R9 irq after mask", irq, 0);
        reg_write(2'd2, 4'b0010);
        reg_read(2'd1, d); check("R3 pending partial mask", d, 4'b1001);
        check("R4 irq partial mask", irq, 1);
        reg_write(2'd1, 4'b0001);
        reg_read(2'd0, d); check("R5 source after pending clear", d, 4'b1010);
        reg_read(2'd1, d); check("R5 pending after pending clear", d, 4'b1000);
        reg_write(2'd2, 4'b1000);
        reg_write(2'd1, 4'b1000);
        reg_read(2'd0, d); check("R5 masked source cleared", d, 4'b0010);
        reg_read(2'd1, d); check("R5 pending kept", d, 4'b0010);
        reg_write(2'd0, 4'b0010);
        reg_read(2'd0, d); check("R6 source clear", d, 0);
        check("R4 irq after clear", irq, 0);
        reg_write(2'd2, 4'b0000);
    endtask

    task automatic t_collision;
        logic [3:0] d;
        pulse(4'b1000);
        @(negedge clk);
        ev_rx = 1'b1; ev_modem = 1'b0;
        wr = 1'b1; addr = 2'd0; wdata = 4'b1001;
        @(negedge clk);
        ev_rx = 1'b0; wr = 1'b0; wdata = '0;
        reg_read(2'd0, d); check("R10 event beats clear", d, 4'b0001);
        reg_write(2'd0, 4'hF);
    endtask

    task automatic tx_case(input bit en, input int f, input int cnt);
        int exp;
        @(negedge clk);
        fifo_en = 1'b0;
        reg_write(2'd0, 4'hF);
        @(negedge clk);
        fifo_en = en; trig = 3'(f); fill = 8'(cnt);
        @(negedge clk);
        @(negedge clk);
        addr = 2'd0;
        #1;
        exp = (en && cnt <= exp_level(0, f)) ? 1 : 0;
        check("R7 R8 tx request ch0", rdata[2], exp);
        for (int k = 0; k < NALT; k++) begin
            exp = (en && cnt <= exp_level(ALT_CH[k], f)) ? 1 : 0;
            check("R8 tx request alt channel", alt_rdata[k][2], exp);
        end
    endtask

    task automatic t_tx;
        tx_case(1, 1, 32);
        tx_case(1, 1, 33);
        tx_case(1, 1, 8);
        tx_case(1, 1, 9);
        tx_case(1, 7, 14);
        tx_case(1, 7, 15);
        tx_case(1, 7, 224);
        tx_case(1, 7, 225);
        tx_case(1, 0, 0);
        tx_case(1, 0, 1);
        tx_case(0, 7, 0);
        @(negedge clk);
        fifo_en = 1'b0;
        reg_write(2'd0, 4'hF);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_events();
        t_mask_and_clear();
        t_collision();
        t_tx();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule